// File: doc/BRIEF.md
# Text Attribute Pixel Formatter

This block sits between the fetch stage and the colour output of a character-cell text display. For every pixel clock it takes the pattern byte and the attribute byte already fetched for the current cell, along with the column and scan line inside the cell, a free-running frame counter and a flag that marks the cursor cell. From these it produces one 4-bit RGBI colour index. Per-cell attributes control flash, a movable underline, reverse video and the choice between two character sets. A hardware cursor covers a programmable band of scan lines and can be solid, off, or blinking at one of two rates.

A global enable turns attributes off. Every cell then takes its colours from a single global colour byte. A global reverse control and a semigraphic option are also available. In semigraphic mode the inter-character spacing columns are filled with the last active pattern pixel instead of being left blank. The block also works out the character-pattern memory address that a fetch unit needs. The row stride of a pattern is 16 or 32 bytes, depending on the cell height.

Top module: `attr_pixel_fmt`

## Requirements
- R1: A pixel in the "set" state takes the foreground colour and a pixel in the "clear" state takes the background colour. The background is always `glob_color[3:0]`. The foreground is `attr_byte[3:0]` when `attr_en` is 1, and `glob_color[7:4]` otherwise.
- R2: The active pixel count is N = min(`active_pix`, 8). A column c < N shows pattern bit `pat_byte[7-c]`, so bit 7 is the leftmost pixel.
- R3: A column c ≥ N is clear when `semigfx` is 0. When `semigfx` is 1 and N > 0, the column repeats the pixel at column N-1. When N = 0, every column is clear.
- R4: On a scan line greater than `vis_lines_m1`, the pattern contributes a clear pixel.
- R5: With attributes enabled and `attr_byte[5]` set, the pixel is forced to set on the scan line equal to `ul_line`. This applies only when `ul_line` ≤ `cell_height_m1`.
- R6: With attributes enabled and `attr_byte[4]` set, the cell is hidden (forced clear, underline included) whenever the blink phase bit is 1. The phase bit is `frame_cnt[3]` when `flash_rate` is 0 and `frame_cnt[4]` when `flash_rate` is 1.
- R7: Per-cell reverse (`attr_byte[6]`, with attributes enabled) inverts the pixel state after flash and underline have been applied. `glob_reverse` also inverts it. When both are active they cancel.
- R8: With `attr_en` = 0, attribute bits 7..4 have no effect: there is no flash, no underline, no reverse, and character set 0 is used.
- R9: When `cursor_hit` is 1 and `cur_start` ≤ line < `cur_end`, the cursor inverts the resolved pixel. It is visible according to `cur_mode`: 00 is always visible, 01 is never visible, 10 is visible while `frame_cnt[3]` is 0, and 11 is visible while `frame_cnt[4]` is 0.
- R10: The stride S is 16 when `cell_height_m1` ≤ 15 and 32 otherwise. The set bit is `attr_byte[7]` & `attr_en`. `pat_addr` is combinational and equals (`charset_base` + set·256·S + `char_code`·S + `scan_line`) mod 2^14.
- R11: `pix_out` is registered and reflects the inputs of the previous clock edge. It reads 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_byte | input | 8 | Fetched pattern byte for this cell and line |
| attr_byte | input | 8 | Attribute byte for this cell |
| char_code | input | 8 | Character code of this cell |
| pix_col | input | 4 | Pixel column inside the cell |
| scan_line | input | 5 | Scan line inside the cell |
| frame_cnt | input | 5 | Free-running frame counter |
| cursor_hit | input | 1 | Current cell is the cursor cell |
| cell_height_m1 | input | 5 | Cell height in lines minus one |
| vis_lines_m1 | input | 5 | Last scan line that shows pattern data |
| active_pix | input | 4 | Pattern pixels shown per cell |
| semigfx | input | 1 | Fill spacing columns with last active pixel |
| ul_line | input | 5 | Underline scan line |
| cur_start | input | 5 | First cursor scan line |
| cur_end | input | 5 | One past the last cursor scan line |
| cur_mode | input | 2 | Cursor mode |
| flash_rate | input | 1 | Flash blink rate select |
| glob_reverse | input | 1 | Global reverse video |
| attr_en | input | 1 | Attribute enable |
| glob_color | input | 8 | Global foreground (7:4) and background (3:0) |
| charset_base | input | 14 | Character-set base address |
| pix_out | output | 4 | RGBI pixel colour index |
| pat_addr | output | 14 | Pattern byte address for the fetch unit |

## Verification
The assertions are checked on every cycle. They cover the following:
- the output colour always comes from one of the two permitted colour sources;
- the spacing columns, the lines beyond the visible count, and all-zero patterns come out as background when attributes, reverse and cursor are off;
- the low address bits follow the scan line for both strides.

Some behaviours depend on how several inputs combine, and only the bench scenarios can show them. These are:
- the precedence between flash, underline, the two reverse sources and the cursor;
- the blink phases taken from the frame counter;
- the semigraphic repeat column;
- the offset added for the second character set.

// File: rtl/afmt_pkg.sv
// Package: shared constants and types for the attribute pixel formatter.
// Assumes an 8-bit attribute byte with a 4-bit colour in the low nibble.
package afmt_pkg;
    localparam int ATTR_FLASH   = 4;
    localparam int ATTR_ULINE   = 5;
    localparam int ATTR_REVERSE = 6;
    localparam int ATTR_SET     = 7;
    localparam int FAST_BLINK_BIT = 3;
    localparam int SLOW_BLINK_BIT = 4;
    localparam int SHORT_CELL_MAX = 15;
    localparam int SHORT_STRIDE_LOG2 = 4;
    localparam int TALL_STRIDE_LOG2  = 5;
    localparam int SET_CODES_LOG2    = 8;

    typedef enum logic [1:0] {
        CUR_SOLID   = 2'b00,
        CUR_HIDDEN  = 2'b01,
        CUR_BLINK16 = 2'b10,
        CUR_BLINK32 = 2'b11
    } cur_mode_e;
endpackage

// File: rtl/afmt_blink.sv
// Blink phase decoder: derives the flash-hide and cursor-visible conditions
// from the free-running frame counter. Assumes FRAME_W > SLOW_BLINK_BIT.
module afmt_blink
    import afmt_pkg::*;
#(
    parameter int FRAME_W = 5
) (
    input  logic [FRAME_W-1:0] frame_cnt,
    input  logic               flash_rate,
    input  logic [1:0]         cur_mode,
    output logic               flash_hide,
    output logic               cursor_shown
);
    logic fast_ph;
    logic slow_ph;
    logic frame_unused_bits;

    assign fast_ph = frame_cnt[FAST_BLINK_BIT];
    assign slow_ph = frame_cnt[SLOW_BLINK_BIT];
    assign frame_unused_bits = ^frame_cnt;

    // Flash hides the cell during the high half of the chosen phase.
    assign flash_hide = flash_rate ? slow_ph : fast_ph;

    // Cursor visibility per mode; blinking modes show during the low half.
    always_comb begin
        case (cur_mode_e'(cur_mode))
            CUR_SOLID:   cursor_shown = 1'b1;
            CUR_HIDDEN:  cursor_shown = 1'b0;
            CUR_BLINK16: cursor_shown = ~fast_ph;
            default:     cursor_shown = ~slow_ph;
        endcase
    end
endmodule

// File: rtl/afmt_pattern.sv
// Pattern bit selector: picks the pattern bit for a pixel column, handling
// active width, spacing columns, semigraphic repeat and blank lines.
// Assumes pix_col lies inside the cell; MSB of the byte is the leftmost pixel.
module afmt_pattern #(
    parameter int PAT_W  = 8,
    parameter int COL_W  = 4,
    parameter int LINE_W = 5
) (
    input  logic [PAT_W-1:0]  pat_byte,
    input  logic [COL_W-1:0]  pix_col,
    input  logic [COL_W-1:0]  active_pix,
    input  logic              semigfx,
    input  logic [LINE_W-1:0] scan_line,
    input  logic [LINE_W-1:0] vis_lines_m1,
    output logic              pat_bit
);
    localparam int IDX_W = $clog2(PAT_W);
    localparam logic [COL_W-1:0] PAT_MAX = COL_W'(PAT_W);

    logic [COL_W-1:0] n_eff;
    logic [COL_W-1:0] rep_col;
    logic [COL_W-1:0] sel_col;
    logic [IDX_W-1:0] bit_idx;
    logic             in_active;
    logic             use_rep;
    logic             line_blank;

    // Clamp the active pixel count to the pattern width.
    assign n_eff     = (active_pix > PAT_MAX) ? PAT_MAX : active_pix;
    assign rep_col   = n_eff - COL_W'(1);
    assign in_active = pix_col < n_eff;
    assign use_rep   = semigfx && (n_eff != '0);
    assign line_blank = scan_line > vis_lines_m1;

    // Choose the column whose bit is displayed and convert to a bit index.
    always_comb begin
        sel_col = in_active ? pix_col : rep_col;
        bit_idx = IDX_W'(PAT_W - 1) - sel_col[IDX_W-1:0];
    end

    // Resolve the pattern contribution for this pixel.
    always_comb begin
        if (line_blank)
            pat_bit = 1'b0;
        else if (in_active || use_rep)
            pat_bit = pat_byte[bit_idx];
        else
            pat_bit = 1'b0;
    end
endmodule

// File: rtl/afmt_addr.sv
// Pattern address generator: forms the character-pattern byte address from
// base, set select, code and scan line, with a stride chosen by cell height.
// Assumes address arithmetic wraps modulo 2^ADDR_W.
module afmt_addr
    import afmt_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CODE_W = 8,
    parameter int LINE_W = 5
) (
    input  logic [ADDR_W-1:0] charset_base,
    input  logic              set_sel,
    input  logic [CODE_W-1:0] char_code,
    input  logic [LINE_W-1:0] scan_line,
    input  logic [LINE_W-1:0] cell_height_m1,
    output logic [ADDR_W-1:0] pat_addr
);
    localparam int SH_W = 4;

    logic [SH_W-1:0]   stride_sh;
    logic [SH_W-1:0]   set_sh;
    logic [ADDR_W-1:0] code_off;
    logic [ADDR_W-1:0] set_off;

    // Stride is 16 bytes for short cells and 32 bytes for tall cells.
    assign stride_sh = (cell_height_m1 > LINE_W'(SHORT_CELL_MAX))
                       ? SH_W'(TALL_STRIDE_LOG2) : SH_W'(SHORT_STRIDE_LOG2);
    assign set_sh    = stride_sh + SH_W'(SET_CODES_LOG2);

    // Offsets for the character code and the second character set.
    always_comb begin
        code_off = ADDR_W'(char_code) << stride_sh;
        set_off  = ADDR_W'(set_sel) << set_sh;
    end

    // Final address sum, wrapping within the pattern memory space.
    assign pat_addr = charset_base + set_off + code_off + ADDR_W'(scan_line);
endmodule

// File: rtl/attr_pixel_fmt.sv
// Attribute pixel formatter top: combines pattern, attribute and cursor state
// into one registered RGBI colour index per pixel clock and drives the
// pattern fetch address. Assumes inputs are stable for the whole pixel clock.
module attr_pixel_fmt
    import afmt_pkg::*;
#(
    parameter int PAT_W   = 8,
    parameter int COL_W   = 4,
    parameter int LINE_W  = 5,
    parameter int CODE_W  = 8,
    parameter int ADDR_W  = 14,
    parameter int FRAME_W = 5,
    parameter int COLOR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAT_W-1:0]     pat_byte,
    input  logic [PAT_W-1:0]     attr_byte,
    input  logic [CODE_W-1:0]    char_code,
    input  logic [COL_W-1:0]     pix_col,
    input  logic [LINE_W-1:0]    scan_line,
    input  logic [FRAME_W-1:0]   frame_cnt,
    input  logic                 cursor_hit,
    input  logic [LINE_W-1:0]    cell_height_m1,
    input  logic [LINE_W-1:0]    vis_lines_m1,
    input  logic [COL_W-1:0]     active_pix,
    input  logic                 semigfx,
    input  logic [LINE_W-1:0]    ul_line,
    input  logic [LINE_W-1:0]    cur_start,
    input  logic [LINE_W-1:0]    cur_end,
    input  logic [1:0]           cur_mode,
    input  logic                 flash_rate,
    input  logic                 glob_reverse,
    input  logic                 attr_en,
    input  logic [2*COLOR_W-1:0] glob_color,
    input  logic [ADDR_W-1:0]    charset_base,
    output logic [COLOR_W-1:0]   pix_out,
    output logic [ADDR_W-1:0]    pat_addr
);
    logic pat_bit;
    logic flash_hide;
    logic cursor_shown;
    logic flash_on, uline_on, rev_on, set_sel;
    logic uline_hit, cursor_band, cursor_flip;
    logic px_state;
    logic [COLOR_W-1:0] fg_color, bg_color, next_pix;

    afmt_blink #(.FRAME_W(FRAME_W)) u_blink (
        .frame_cnt    (frame_cnt),
        .flash_rate   (flash_rate),
        .cur_mode     (cur_mode),
        .flash_hide   (flash_hide),
        .cursor_shown (cursor_shown)
    );

    afmt_pattern #(.PAT_W(PAT_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_pat (
        .pat_byte     (pat_byte),
        .pix_col      (pix_col),
        .active_pix   (active_pix),
        .semigfx      (semigfx),
        .scan_line    (scan_line),
        .vis_lines_m1 (vis_lines_m1),
        .pat_bit      (pat_bit)
    );

    afmt_addr #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .LINE_W(LINE_W)) u_addr (
        .charset_base   (charset_base),
        .set_sel        (set_sel),
        .char_code      (char_code),
        .scan_line      (scan_line),
        .cell_height_m1 (cell_height_m1),
        .pat_addr       (pat_addr)
    );

    // Attribute decode, gated by the global attribute enable.
    assign flash_on = attr_en & attr_byte[ATTR_FLASH];
    assign uline_on = attr_en & attr_byte[ATTR_ULINE];
    assign rev_on   = attr_en & attr_byte[ATTR_REVERSE];
    assign set_sel  = attr_en & attr_byte[ATTR_SET];

    // Underline line match, only when the line lies inside the cell.
    assign uline_hit = uline_on && (scan_line == ul_line) && (ul_line <= cell_height_m1);

    // Cursor band test and final inversion enable.
    assign cursor_band = (scan_line >= cur_start) && (scan_line < cur_end);
    assign cursor_flip = cursor_hit && cursor_shown && cursor_band;

    // Colour sources: per-cell foreground when attributes are on.
    assign fg_color = attr_en ? attr_byte[COLOR_W-1:0] : glob_color[2*COLOR_W-1:COLOR_W];
    assign bg_color = glob_color[COLOR_W-1:0];

    // Resolve the pixel state: pattern/underline, flash, reverse, then cursor.
    always_comb begin
        px_state = pat_bit | uline_hit;
        if (flash_on && flash_hide)
            px_state = 1'b0;
        px_state = px_state ^ rev_on ^ glob_reverse;
        px_state = px_state ^ cursor_flip;
        next_pix = px_state ? fg_color : bg_color;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_out <= '0;
        else
            pix_out <= next_pix;
    end
endmodule

// File: rtl/afmt_checker.sv
// Checker for the attribute pixel formatter: concurrent properties on the
// registered colour output and the pattern address; bound to the top module.
module afmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pat_byte,
    input logic [7:0] attr_byte,
    input logic [3:0] pix_col,
    input logic [4:0] scan_line,
    input logic [4:0] cell_height_m1,
    input logic [4:0] vis_lines_m1,
    input logic [3:0] active_pix,
    input logic       semigfx,
    input logic [1:0] cur_mode,
    input logic       glob_reverse,
    input logic       attr_en,
    input logic [7:0] glob_color,
    input logic [13:0] charset_base,
    input logic [3:0] pix_out,
    input logic [13:0] pat_addr
);
    p_color_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pix_out == $past(glob_color[3:0])) ||
                         (pix_out == $past(attr_en ? attr_byte[3:0] : glob_color[7:4])));

    p_spacing_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !attr_en && !glob_reverse && cur_mode == 2'b01 &&
              !semigfx && pix_col >= active_pix)
        |-> pix_out == $past(glob_color[3:0]));

    p_blank_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !attr_en && !glob_reverse && cur_mode == 2'b01 &&
              scan_line > vis_lines_m1)
        |-> pix_out == $past(glob_color[3:0]));

    p_attr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !attr_en && !glob_reverse && cur_mode == 2'b01 &&
              pat_byte == 8'h00)
        |-> pix_out == $past(glob_color[3:0]));

    p_addr_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_height_m1 <= 5'd15 && charset_base[3:0] == 4'h0)
        |-> pat_addr[3:0] == scan_line[3:0]);

    p_addr_tall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_height_m1 > 5'd15 && charset_base[4:0] == 5'h00)
        |-> pat_addr[4:0] == scan_line);
endmodule

bind attr_pixel_fmt afmt_checker u_chk (.*);

// File: tb/attr_pixel_fmt_test.sv
module attr_pixel_fmt_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pat_byte = '0, attr_byte = '0, char_code = '0, glob_color = '0;
    logic [3:0] pix_col = '0, active_pix = '0;
    logic [4:0] scan_line = '0, frame_cnt = '0, cell_height_m1 = '0, vis_lines_m1 = '0;
    logic [4:0] ul_line = '0, cur_start = '0, cur_end = '0;
    logic [1:0] cur_mode = '0;
    logic       cursor_hit = 1'b0, semigfx = 1'b0, flash_rate = 1'b0;
    logic       glob_reverse = 1'b0, attr_en = 1'b0;
    logic [13:0] charset_base = '0;
    logic [3:0] pix_out;
    logic [13:0] pat_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    attr_pixel_fmt uut (.*);

    function automatic logic [3:0] ref_pix();
        int  n;
        logic b;
        logic ae;
        logic cur_vis;
        n = (active_pix > 8) ? 8 : int'(active_pix);
        if (int'(pix_col) < n) b = pat_byte[7 - pix_col];
        else if (semigfx && n > 0) b = pat_byte[8 - n];
        else b = 1'b0;
        if (scan_line > vis_lines_m1) b = 1'b0;
        ae = attr_en;
        if (ae && attr_byte[5] && scan_line == ul_line && ul_line <= cell_height_m1) b = 1'b1;
        if (ae && attr_byte[4] && (flash_rate ? frame_cnt[4] : frame_cnt[3])) b = 1'b0;
        if (ae && attr_byte[6]) b = ~b;
        if (glob_reverse) b = ~b;
        case (cur_mode)
            2'b00: cur_vis = 1'b1;
            2'b01: cur_vis = 1'b0;
            2'b10: cur_vis = ~frame_cnt[3];
            default: cur_vis = ~frame_cnt[4];
        endcase
        if (cursor_hit && cur_vis && scan_line >= cur_start && scan_line < cur_end) b = ~b;
        return b ? (ae ? attr_byte[3:0] : glob_color[7:4]) : glob_color[3:0];
    endfunction

    function automatic logic [13:0] ref_addr();
        int stride;
        int a;
        stride = (cell_height_m1 > 15) ? 32 : 16;
        a = int'(charset_base) + ((attr_en && attr_byte[7]) ? 256 * stride : 0)
            + int'(char_code) * stride + int'(scan_line);
        return 14'(a);
    endfunction

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pix_out actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge (already there), check address, clock, check pixel.
    task automatic step(input string req);
        logic [3:0]  ep;
        logic [13:0] ea;
        ep = ref_pix();
        ea = ref_addr();
        #1;
        checks++;
        if (pat_addr !== ea) begin
            errors++;
            $display("FAIL R10 pat_addr actual %h expected %h", pat_addr, ea);
        end
        @(posedge clk);
        @(negedge clk);
        check4(req, pix_out, ep);
    endtask

    task automatic defaults();
        pat_byte = 8'h00; attr_byte = 8'h00; char_code = 8'h00; glob_color = 8'hF0;
        pix_col = 0; active_pix = 8; scan_line = 0; frame_cnt = 0;
        cell_height_m1 = 7; vis_lines_m1 = 7; ul_line = 7;
        cur_start = 0; cur_end = 0; cur_mode = 2'b01; cursor_hit = 0;
        semigfx = 0; flash_rate = 0; glob_reverse = 0; attr_en = 1; charset_base = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        defaults();
        @(negedge clk); @(negedge clk);
        check4("R11 reset", pix_out, 4'h0);
        rst_n = 1'b1;

        // R1/R2: MSB-first pattern with per-cell foreground
        defaults(); pat_byte = 8'h80; attr_byte = 8'h0A; pix_col = 0; step("R2 col0 set");
        pix_col = 1; step("R2 col1 clear");
        attr_en = 0; pix_col = 0; glob_color = 8'h5C; step("R1 global fg");
        // R3: spacing and semigraphic repeat
        defaults(); pat_byte = 8'h01; attr_byte = 8'h03; active_pix = 12; pix_col = 9; step("R3 clamp to 8 spacing blank");
        semigfx = 1; step("R3 semigraphic repeat bit0");
        active_pix = 3; pat_byte = 8'h20; pix_col = 6; step("R3 repeat col2");
        active_pix = 0; step("R3 zero width blank");
        // R4: blank line
        defaults(); pat_byte = 8'hFF; attr_byte = 8'h07; scan_line = 6; vis_lines_m1 = 5; step("R4 blank line");
        // R5: underline in and out of cell
        defaults(); attr_byte = 8'h29; scan_line = 7; ul_line = 7; step("R5 underline on");
        ul_line = 9; scan_line = 9; step("R5 underline outside cell");
        // R6: flash rates
        defaults(); pat_byte = 8'hFF; attr_byte = 8'h1E; frame_cnt = 5'b01000; step("R6 fast hidden");
        flash_rate = 1; step("R6 slow shown");
        frame_cnt = 5'b10000; step("R6 slow hidden");
        // R7: reverse cancel
        defaults(); pat_byte = 8'h80; attr_byte = 8'h4B; step("R7 cell reverse");
        glob_reverse = 1; step("R7 both cancel");
        // R8: attributes ignored when disabled
        defaults(); attr_en = 0; attr_byte = 8'hFF; ul_line = 0; frame_cnt = 5'b11000;
        pat_byte = 8'h80; step("R8 attr off no flash/uline/rev/set");
        // R9: cursor modes
        defaults(); cursor_hit = 1; cur_start = 2; cur_end = 5; scan_line = 4; cur_mode = 2'b00; attr_byte = 8'h09;
        step("R9 solid in band");
        scan_line = 5; step("R9 end exclusive");
        scan_line = 2; cur_mode = 2'b10; frame_cnt = 5'b01000; step("R9 blink16 off phase");
        cur_mode = 2'b11; step("R9 blink32 on phase");
        // R10: tall stride and second set
        defaults(); cell_height_m1 = 20; attr_byte = 8'h80; char_code = 8'h41; scan_line = 19;
        charset_base = 14'h0123; step("R10 tall set1");

        // Random mix over all requirements
        for (int i = 0; i < 4000; i++) begin
            pat_byte = 8'($urandom); attr_byte = 8'($urandom); char_code = 8'($urandom);
            glob_color = 8'($urandom); active_pix = 4'($urandom);
            pix_col = 4'($urandom_range(0, 15));
            cell_height_m1 = 5'($urandom); scan_line = 5'($urandom_range(0, 31));
            vis_lines_m1 = 5'($urandom); ul_line = 5'($urandom);
            frame_cnt = 5'($urandom); cursor_hit = 1'($urandom);
            cur_start = 5'($urandom); cur_end = 5'($urandom); cur_mode = 2'($urandom);
            semigfx = 1'($urandom); flash_rate = 1'($urandom);
            glob_reverse = 1'($urandom); attr_en = 1'($urandom);
            charset_base = 14'($urandom);
            step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule